// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit sits beside the integer datapath of a small 32-bit core. For each instruction it takes the operation class, the two operand values, a displacement or immediate field, the instruction address and the current condition flag. It produces the next condition flag, a taken indication, the branch target and, for call-type operations, the return address. Register-file access, writeback and instruction fetch belong to neighbouring blocks.

Compare operations and the carry-chained add and subtract write the condition flag. Every other operation passes the flag through unchanged. Targets relative to the PC are formed from the instruction address with its low two bits cleared, plus a sign-extended displacement scaled by four. The displacement can be 8, 16 or 24 bits wide. Register jumps take their target from operand A with its low two bits cleared. The carry and borrow of the multi-word add and subtract travel through the single condition flag.

All outputs come from flip-flops, so results appear one clock after the inputs are presented. A synchronous, active-high reset clears every output.

Top module: `bcu_top`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero on the following cycle. Otherwise each output reflects the inputs sampled at the previous rising edge.
- R2: Unless the operation is a register jump, `target_o` = (`pc_i` with bits 1:0 cleared) + (sign-extended displacement × 4), modulo 2^32. `dsel_i` = 0 selects `disp_i[7:0]`, 1 selects `disp_i[15:0]`, and 2 or 3 selects all 24 bits.
- R3: For the call codes 18 (PC-relative call) and 20 (register call), `link_en_o` = 1 and `link_o` = (`pc_i` with bits 1:0 cleared) + 4. For all other codes, both are 0.
- R4: Code 1 sets the flag to the signed compare a < b. Code 3 sets it to the signed compare a < sext(`disp_i[15:0]`). Operand B is ignored by code 3.
- R5: Code 2 sets the flag to the unsigned compare a < b. Code 4 sets it to the unsigned compare a < sext(`disp_i[15:0]`), where the immediate is sign-extended before the unsigned compare.
- R6: Code 5 gives `sum_o` = a + b + flag (mod 2^32) and sets the flag to the carry out of bit 31.
- R7: Code 6 gives `sum_o` = a − b − flag (mod 2^32) and sets the flag to the unsigned compare a < b. The incoming flag does not enter the new flag.
- R8: Code 7 is taken when a == b, and code 8 is taken when a != b.
- R9: Codes 9 to 14 compare signed A against zero: == (9), != (10), < (11), >= (12), <= (13), > (14). The branch is taken when the comparison holds.
- R10: Code 15 is taken when the incoming flag is 1, and code 16 when it is 0. Codes 17 and 18 are always taken.
- R11: Codes 19 (register jump) and 20 (register call) are always taken, with `target_o` = A with bits 1:0 cleared.
- R12: Code 0, the branch codes, and the unassigned codes 21 to 31 leave the flag unchanged. `taken_o` is 0 for every code not listed as taken above. `sum_o` is 0 except for codes 5 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation class code |
| dsel_i | input | 2 | Displacement width select |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| disp_i | input | 24 | Displacement / immediate field |
| pc_i | input | 32 | Instruction address |
| cond_i | input | 1 | Current condition flag |
| cond_o | output | 1 | Next condition flag |
| taken_o | output | 1 | Branch or jump taken |
| target_o | output | 32 | Branch target address |
| link_en_o | output | 1 | Return address valid |
| link_o | output | 32 | Return address |
| sum_o | output | 32 | Carry-chained add/subtract result |

## Verification
The only state in the unit is the output register stage. A fault therefore shows up at the ports on the very next cycle for the instruction that triggers it, and it cannot persist past the following instruction. The risky spots are the sign extension at each displacement width, the wrap of targets across address zero, and the carry and borrow at 0xFFFFFFFF and zero. Each of these is driven directly, and a mistake there appears as a wrong target, flag or sum one clock later. Signed versus unsigned confusion in the compares is exposed by operands whose top bits differ.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NONE    = 5'd0,
    OP_CMP_S   = 5'd1,
    OP_CMP_U   = 5'd2,
    OP_CMPI_S  = 5'd3,
    OP_CMPI_U  = 5'd4,
    OP_ADD_C   = 5'd5,
    OP_SUB_B   = 5'd6,
    OP_BR_EQ   = 5'd7,
    OP_BR_NE   = 5'd8,
    OP_BZ_EQ   = 5'd9,
    OP_BZ_NE   = 5'd10,
    OP_BZ_LT   = 5'd11,
    OP_BZ_GE   = 5'd12,
    OP_BZ_LE   = 5'd13,
    OP_BZ_GT   = 5'd14,
    OP_BR_C    = 5'd15,
    OP_BR_NC   = 5'd16,
    OP_BR_AL   = 5'd17,
    OP_CALL    = 5'd18,
    OP_JREG    = 5'd19,
    OP_JCALL   = 5'd20
  } bcu_op_e;

  localparam logic [1:0] DSEL_SHORT = 2'd0;
  localparam logic [1:0] DSEL_MID   = 2'd1;
endpackage

// File: rtl/bcu_disp_ext.sv
module bcu_disp_ext
  import bcu_pkg::*;
#(
  parameter int W       = 32,
  parameter int DISP_W  = 24,
  parameter int SHORT_W = 8,
  parameter int MID_W   = 16
) (
  input  logic [1:0]        dsel_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [W-1:0]      off_o,
  output logic [W-1:0]      imm_o
);
  logic [W-1:0] short_x, mid_x, long_x;

  assign short_x = {{(W-SHORT_W){disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
  assign mid_x   = {{(W-MID_W){disp_i[MID_W-1]}}, disp_i[MID_W-1:0]};
  assign long_x  = {{(W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign imm_o   = mid_x;

  always_comb begin
    case (dsel_i)
      DSEL_SHORT: off_o = short_x;
      DSEL_MID:   off_o = mid_x;
      default:    off_o = long_x;
    endcase
  end
endmodule

// File: rtl/bcu_cond_alu.sv
module bcu_cond_alu
  import bcu_pkg::*;
#(
  parameter int W = 32
) (
  input  bcu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] imm_i,
  input  logic         cond_i,
  output logic         cond_o,
  output logic [W-1:0] sum_o
);
  logic [W:0]   add_full;
  logic [W-1:0] sub_res;
  logic [W-1:0] cin;

  assign cin      = {{(W-1){1'b0}}, cond_i};
  assign add_full = {1'b0, a_i} + {1'b0, b_i} + {1'b0, cin};
  assign sub_res  = a_i - b_i - cin;

  always_comb begin
    cond_o = cond_i;
    sum_o  = '0;
    case (op_i)
      OP_CMP_S:  cond_o = $signed(a_i) < $signed(b_i);
      OP_CMP_U:  cond_o = a_i < b_i;
      OP_CMPI_S: cond_o = $signed(a_i) < $signed(imm_i);
      OP_CMPI_U: cond_o = a_i < imm_i;
      OP_ADD_C: begin
        sum_o  = add_full[W-1:0];
        cond_o = add_full[W];
      end
      OP_SUB_B: begin
        sum_o  = sub_res;
        cond_o = a_i < b_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bcu_branch_eval.sv
module bcu_branch_eval
  import bcu_pkg::*;
#(
  parameter int W = 32
) (
  input  bcu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] off_i,
  input  logic         cond_i,
  output logic         taken_o,
  output logic [W-1:0] target_o,
  output logic         link_en_o,
  output logic [W-1:0] link_o
);
  localparam logic [W-1:0] STEP = W'(4);

  logic [W-1:0] pc_al, a_al, rel_tgt, ret_addr;
  logic         a_zero, a_neg;

  assign pc_al    = {pc_i[W-1:2], 2'b00};
  assign a_al     = {a_i[W-1:2], 2'b00};
  assign rel_tgt  = pc_al + {off_i[W-3:0], 2'b00};
  assign ret_addr = pc_al + STEP;
  assign a_zero   = (a_i == '0);
  assign a_neg    = a_i[W-1];

  always_comb begin
    taken_o   = 1'b0;
    target_o  = rel_tgt;
    link_en_o = 1'b0;
    link_o    = '0;
    case (op_i)
      OP_BR_EQ: taken_o = (a_i == b_i);
      OP_BR_NE: taken_o = (a_i != b_i);
      OP_BZ_EQ: taken_o = a_zero;
      OP_BZ_NE: taken_o = !a_zero;
      OP_BZ_LT: taken_o = a_neg;
      OP_BZ_GE: taken_o = !a_neg;
      OP_BZ_LE: taken_o = a_neg || a_zero;
      OP_BZ_GT: taken_o = !a_neg && !a_zero;
      OP_BR_C:  taken_o = cond_i;
      OP_BR_NC: taken_o = !cond_i;
      OP_BR_AL: taken_o = 1'b1;
      OP_CALL: begin
        taken_o   = 1'b1;
        link_en_o = 1'b1;
        link_o    = ret_addr;
      end
      OP_JREG: begin
        taken_o  = 1'b1;
        target_o = a_al;
      end
      OP_JCALL: begin
        taken_o   = 1'b1;
        target_o  = a_al;
        link_en_o = 1'b1;
        link_o    = ret_addr;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bcu_top.sv
module bcu_top
  import bcu_pkg::*;
#(
  parameter int W      = 32,
  parameter int DISP_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [1:0]        dsel_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [W-1:0]      pc_i,
  input  logic              cond_i,
  output logic              cond_o,
  output logic              taken_o,
  output logic [W-1:0]      target_o,
  output logic              link_en_o,
  output logic [W-1:0]      link_o,
  output logic [W-1:0]      sum_o
);
  bcu_op_e      op;
  logic [W-1:0] off, imm, sum_d, tgt_d, link_d;
  logic         cond_d, taken_d, link_en_d;

  assign op = bcu_op_e'(op_i);

  bcu_disp_ext #(.W(W), .DISP_W(DISP_W)) u_ext (
    .dsel_i(dsel_i), .disp_i(disp_i), .off_o(off), .imm_o(imm)
  );

  bcu_cond_alu #(.W(W)) u_alu (
    .op_i(op), .a_i(a_i), .b_i(b_i), .imm_i(imm), .cond_i(cond_i),
    .cond_o(cond_d), .sum_o(sum_d)
  );

  bcu_branch_eval #(.W(W)) u_br (
    .op_i(op), .a_i(a_i), .b_i(b_i), .pc_i(pc_i), .off_i(off),
    .cond_i(cond_i), .taken_o(taken_d), .target_o(tgt_d),
    .link_en_o(link_en_d), .link_o(link_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_o    <= 1'b0;
      taken_o   <= 1'b0;
      target_o  <= '0;
      link_en_o <= 1'b0;
      link_o    <= '0;
      sum_o     <= '0;
    end else begin
      cond_o    <= cond_d;
      taken_o   <= taken_d;
      target_o  <= tgt_d;
      link_en_o <= link_en_d;
      link_o    <= link_d;
      sum_o     <= sum_d;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!cond_o && !taken_o && target_o == '0 && !link_en_o &&
             link_o == '0 && sum_o == '0));

  assert_no_link_R3: assert property (@(posedge clk) disable iff (rst)
    !(op_i == OP_CALL || op_i == OP_JCALL) |=> (!link_en_o && link_o == '0));

  assert_cmp_equal_R4: assert property (@(posedge clk) disable iff (rst)
    ((op_i == OP_CMP_S || op_i == OP_CMP_U) && a_i == b_i) |=> !cond_o);

  assert_always_taken_R10: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_BR_AL || op_i == OP_CALL) |=> taken_o);

  assert_jump_aligned_R11: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_JREG || op_i == OP_JCALL) |=> (taken_o && target_o[1:0] == 2'b00));

  assert_flag_pass_R12: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NONE) |=> (cond_o == $past(cond_i) && !taken_o && sum_o == '0));
endmodule

// File: tb/tb_bcu_top.sv
module tb_bcu_top;
  import bcu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = '0;
  logic [1:0]  dsel_i = '0;
  logic [31:0] a_i = '0, b_i = '0, pc_i = '0;
  logic [23:0] disp_i = '0;
  logic        cond_i = 1'b0;
  logic        cond_o, taken_o, link_en_o;
  logic [31:0] target_o, link_o, sum_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bcu_top dut (
    .clk(clk), .rst(rst), .op_i(op_i), .dsel_i(dsel_i), .a_i(a_i), .b_i(b_i),
    .disp_i(disp_i), .pc_i(pc_i), .cond_i(cond_i), .cond_o(cond_o),
    .taken_o(taken_o), .target_o(target_o), .link_en_o(link_en_o),
    .link_o(link_o), .sum_o(sum_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [4:0] op);
    case (op)
      OP_CMP_S, OP_CMPI_S: return "R4";
      OP_CMP_U, OP_CMPI_U: return "R5";
      OP_ADD_C: return "R6";
      OP_SUB_B: return "R7";
      OP_BR_EQ, OP_BR_NE: return "R8";
      OP_BZ_EQ, OP_BZ_NE, OP_BZ_LT, OP_BZ_GE, OP_BZ_LE, OP_BZ_GT: return "R9";
      OP_BR_C, OP_BR_NC, OP_BR_AL, OP_CALL: return "R10";
      OP_JREG, OP_JCALL: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic void model(
    input logic [4:0] op, input logic [1:0] ds, input logic [31:0] a, b,
    input logic [23:0] d, input logic [31:0] pc, input logic c,
    output logic ec, output logic et, output logic [31:0] etg,
    output logic el, output logic [31:0] elk, output logic [31:0] es);
    longint off, pcb, ua, ub, s;
    int t, simm;
    case (ds)
      2'd0: off = longint'(byte'(d[7:0]));
      2'd1: off = longint'(shortint'(d[15:0]));
      default: begin t = int'({d, 8'h00}); off = longint'(t >>> 8); end
    endcase
    simm = int'(shortint'(d[15:0]));
    ua = longint'(a);
    ub = longint'(b);
    pcb = longint'(pc) & 64'h0000_0000_FFFF_FFFC;
    etg = 32'(pcb + off * 4);
    ec = c; et = 0; el = 0; elk = '0; es = '0;
    case (op)
      OP_CMP_S:  ec = $signed(a) < $signed(b);
      OP_CMP_U:  ec = ua < ub;
      OP_CMPI_S: ec = $signed(a) < simm;
      OP_CMPI_U: ec = ua < (longint'(simm) & 64'hFFFF_FFFF);
      OP_ADD_C:  begin s = ua + ub + longint'(c); es = 32'(s); ec = s > 64'hFFFF_FFFF; end
      OP_SUB_B:  begin s = ua - ub - longint'(c); es = 32'(s); ec = ua < ub; end
      OP_BR_EQ:  et = (a == b);
      OP_BR_NE:  et = (a != b);
      OP_BZ_EQ:  et = ($signed(a) == 0);
      OP_BZ_NE:  et = ($signed(a) != 0);
      OP_BZ_LT:  et = ($signed(a) < 0);
      OP_BZ_GE:  et = ($signed(a) >= 0);
      OP_BZ_LE:  et = ($signed(a) <= 0);
      OP_BZ_GT:  et = ($signed(a) > 0);
      OP_BR_C:   et = c;
      OP_BR_NC:  et = !c;
      OP_BR_AL:  et = 1;
      OP_CALL:   begin et = 1; el = 1; elk = 32'(pcb + 4); end
      OP_JREG:   begin et = 1; etg = a & 32'hFFFF_FFFC; end
      OP_JCALL:  begin et = 1; etg = a & 32'hFFFF_FFFC; el = 1; elk = 32'(pcb + 4); end
      default: ;
    endcase
  endfunction

  // called at a falling edge; outputs are compared at the next falling edge
  task automatic apply(input logic [4:0] op, input logic [1:0] ds,
                       input logic [31:0] a, b, input logic [23:0] d,
                       input logic [31:0] pc, input logic c);
    logic ec, et, el;
    logic [31:0] etg, elk, es;
    string rq;
    op_i = op; dsel_i = ds; a_i = a; b_i = b; disp_i = d; pc_i = pc; cond_i = c;
    model(op, ds, a, b, d, pc, c, ec, et, etg, el, elk, es);
    rq = req_of(op);
    @(negedge clk);
    check(rq, "cond", 32'(cond_o), 32'(ec));
    check(rq, "taken", 32'(taken_o), 32'(et));
    check((op == OP_JREG || op == OP_JCALL) ? "R11" : "R2", "target", target_o, etg);
    check("R3", "link_en", 32'(link_en_o), 32'(el));
    check("R3", "link", link_o, elk);
    check((op == OP_ADD_C) ? "R6" : (op == OP_SUB_B) ? "R7" : "R12", "sum", sum_o, es);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset clears outputs even with an always-taken call presented
    op_i = OP_CALL; a_i = 32'hFFFF_FFFF; pc_i = 32'h1000; cond_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "cond", 32'(cond_o), 0);
    check("R1", "taken", 32'(taken_o), 0);
    check("R1", "target", target_o, 0);
    check("R1", "link_en", 32'(link_en_o), 0);
    check("R1", "link", link_o, 0);
    check("R1", "sum", sum_o, 0);
    rst = 1'b0;

    // R4 / R5: sign sensitivity of compares
    apply(OP_CMP_S,  2'd0, 32'hFFFF_FFFF, 32'd1, 24'h0, 32'h0, 1'b0);
    apply(OP_CMP_U,  2'd0, 32'hFFFF_FFFF, 32'd1, 24'h0, 32'h0, 1'b0);
    apply(OP_CMPI_U, 2'd0, 32'd5, 32'd0, 24'h00FFFF, 32'h0, 1'b0);
    apply(OP_CMPI_S, 2'd0, 32'd5, 32'd99, 24'h00FFFF, 32'h0, 1'b1);
    apply(OP_CMP_S,  2'd0, 32'd7, 32'd7, 24'h0, 32'h0, 1'b1);
    // R6 / R7: carry and borrow boundaries
    apply(OP_ADD_C, 2'd0, 32'hFFFF_FFFF, 32'd0, 24'h0, 32'h0, 1'b1);
    apply(OP_ADD_C, 2'd0, 32'h8000_0000, 32'h7FFF_FFFF, 24'h0, 32'h0, 1'b0);
    apply(OP_SUB_B, 2'd0, 32'd0, 32'd1, 24'h0, 32'h0, 1'b1);
    apply(OP_SUB_B, 2'd0, 32'd5, 32'd5, 24'h0, 32'h0, 1'b1);
    // R2: displacement widths and wrap
    apply(OP_BR_C,  2'd0, 32'd0, 32'd0, 24'h000080, 32'h0000_1002, 1'b1);
    apply(OP_BR_C,  2'd0, 32'd0, 32'd0, 24'h000080, 32'h0000_1002, 1'b0);
    apply(OP_BR_NC, 2'd1, 32'd0, 32'd0, 24'h007FFF, 32'h0000_0003, 1'b0);
    apply(OP_BR_AL, 2'd2, 32'd0, 32'd0, 24'h800000, 32'h0000_0000, 1'b0);
    apply(OP_BR_AL, 2'd3, 32'd0, 32'd0, 24'h000001, 32'hFFFF_FFFE, 1'b0);
    // R3 / R11: calls and register jumps
    apply(OP_CALL,  2'd1, 32'd0, 32'd0, 24'h00FFFE, 32'h0000_2003, 1'b0);
    apply(OP_JREG,  2'd0, 32'h0000_1237, 32'd0, 24'h0, 32'h40, 1'b1);
    apply(OP_JCALL, 2'd0, 32'hFFFF_FFFF, 32'd0, 24'h0, 32'hFFFF_FFFD, 1'b0);
    // R8 / R9: register and zero compares
    apply(OP_BR_EQ, 2'd1, 32'd9, 32'd9, 24'h10, 32'h100, 1'b0);
    apply(OP_BR_NE, 2'd1, 32'd9, 32'd9, 24'h10, 32'h100, 1'b0);
    for (int k = 0; k < 3; k++) begin
      for (int o = OP_BZ_EQ; o <= OP_BZ_GT; o++)
        apply(5'(o), 2'd1, (k == 0) ? 32'd0 : (k == 1) ? 32'd1 : 32'hFFFF_FFFF,
              32'd0, 24'h20, 32'h400, 1'b1);
    end
    // R12: flag passes through on non-compare and unassigned codes
    apply(OP_NONE, 2'd0, 32'd1, 32'd2, 24'h0, 32'h0, 1'b1);
    apply(5'd25,   2'd0, 32'd1, 32'd2, 24'h0, 32'h0, 1'b1);
    apply(OP_BR_EQ, 2'd0, 32'd1, 32'd2, 24'h0, 32'h0, 1'b1);

    // mixed traffic across all codes
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = ($urandom_range(0, 3) == 0) ? ra : 32'($urandom);
      if ($urandom_range(0, 7) == 0) ra = '0;
      apply(5'($urandom_range(0, 31)), 2'($urandom_range(0, 3)), ra, rb,
            24'($urandom), 32'($urandom), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule